// File: doc/BRIEF.md
# CEC Transmit Frame Buffer Controller

This block keeps one outgoing CEC frame of up to sixteen bytes and manages its hand-off to a separate bit-level line engine. Software fills the frame through a byte-wide register write port. It sets the byte count minus one and then issues a two-bit command: no-op, send, abort, or send-next. The block starts the engine, supplies the frame one byte at a time on request, and tracks each attempt in a two-bit status code. It raises a one-cycle interrupt whenever an attempt ends.

The line engine reports how an attempt ended through three inputs: done, nack/error, and arbitration lost. After an attempt ends, the final status is held until software writes the no-op command. This lets the interrupt handler read the result before the block goes idle.

Register address map: frame bytes at 0x00–0x0F (header at 0x00, opcode at 0x01, operands after them), count-minus-one at 0x10, command at 0x11, buffer clear at 0x13. Status is brought out directly on a port.

Top module: `cec_txbuf_top`

## Requirements
- R1: After reset the status is idle (0), the interrupt, start and abort outputs are low, the frame bytes and length are zero, the engine byte output is 0, and the last-byte flag is high.
- R2: A byte written to address 0x00+i (i in 0..15) is presented on the engine byte output as frame byte i during a send, in ascending index order starting from index 0.
- R3: The length register at 0x10 holds the byte count minus one, and the last-byte flag is high while frame byte index equals that value. A written value above 15 is stored as 15.
- R4: Command 1 written to 0x11 while the status is idle moves the status to busy (1) on the same clock edge, and pulses the start output for one cycle. Command 1 in any other status has no effect.
- R5: While sending, an engine done moves the status to 2 and an engine nack moves it to 3; nack wins when both arrive together. Each raises the interrupt for exactly one cycle, after the edge that samples the event. Engine completions while not sending are ignored.
- R6: An arbitration-lost report while sending raises the interrupt for one cycle and leaves the status at busy (1), with the attempt ended.
- R7: Command 2 while sending moves the status to 3, pulses the abort output and the interrupt for one cycle. Command 2 while not sending has no effect.
- R8: Command 0 returns the status to idle from 2, from 3, or from busy after an ended attempt. Command 0 during an active send is ignored.
- R9: Command 3 starts a send (status busy, start pulse, byte index 0) from idle, 2 or 3, and discards any held completion state.
- R10: Writing 1 to 0x13 empties the frame (bytes and length read as zero) and holds it empty. Byte and length writes are ignored until 0 is written to 0x13.
- R11: Byte and length writes are ignored while the status is busy.
- R12: The byte index advances by one on each engine byte request during an active send, and stops at the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWrData | input | 8 | Register write data |
| engByteReq | input | 1 | Engine consumed the current byte |
| engDone | input | 1 | Engine: frame sent and acknowledged |
| engNack | input | 1 | Engine: frame ended with nack or error |
| engArbLost | input | 1 | Engine: arbitration lost |
| txStatus | output | 2 | 0 idle, 1 busy, 2 sent, 3 error |
| txIrq | output | 1 | One-cycle interrupt at attempt end |
| engStart | output | 1 | One-cycle request to start sending |
| engAbort | output | 1 | One-cycle request to stop sending |
| engByte | output | 8 | Frame byte at the current index |
| engLast | output | 1 | Current index is the last byte |

## Verification
A wrong byte index or length shows up at once on the engine byte output and the last-byte flag. The error is visible in the first cycle after a start, or after the request that moved the index. A wrong status code or a lost sending flag appears on the status port in the cycle after the command or engine event. It also shows as a missing or doubled interrupt pulse in that same cycle. Writes that should have been ignored are exposed the next time the frame is streamed out.

// File: rtl/cec_txbuf_pkg.sv
package cec_txbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } txStat_e;

  typedef enum logic [1:0] {
    CMD_NOP       = 2'd0,
    CMD_SEND      = 2'd1,
    CMD_ABORT     = 2'd2,
    CMD_SEND_NEXT = 2'd3
  } txCmd_e;

  typedef struct packed {
    logic wrOk;
    logic ptrLoad;
    logic ptrAdv;
  } txStrobe_t;
endpackage

// File: rtl/cec_txbuf_ctl.sv
module cec_txbuf_ctl
  import cec_txbuf_pkg::*;
#(
  parameter int MSG_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              engByteReq,
  input  logic              engDone,
  input  logic              engNack,
  input  logic              engArbLost,
  output txStrobe_t         strobe,
  output logic [1:0]        txStatus,
  output logic              txIrq,
  output logic              engStart,
  output logic              engAbort
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(MSG_BYTES + 1);

  txStat_e statQ, statD;
  logic    sendingQ, sendingD;
  logic    startNow, abortNow, irqNow;
  logic    cmdWr, anyEnd;
  txCmd_e  cmdVal;

  assign cmdWr  = regWrEn && (regAddr == CMD_ADDR);
  assign cmdVal = txCmd_e'(regWrData[1:0]);
  assign anyEnd = sendingQ && (engDone || engNack || engArbLost);

  always_comb begin
    statD    = statQ;
    sendingD = sendingQ;
    startNow = 1'b0;
    abortNow = 1'b0;
    irqNow   = 1'b0;
    if (anyEnd) begin
      sendingD = 1'b0;
      irqNow   = 1'b1;
      if (engNack)      statD = ST_ERR;
      else if (engDone) statD = ST_DONE;
    end else if (cmdWr) begin
      unique case (cmdVal)
        CMD_NOP:       if (!sendingQ) statD = ST_IDLE;
        CMD_SEND:      if (statQ == ST_IDLE) startNow = 1'b1;
        CMD_ABORT:     if (sendingQ) begin
                         statD    = ST_ERR;
                         sendingD = 1'b0;
                         abortNow = 1'b1;
                         irqNow   = 1'b1;
                       end
        CMD_SEND_NEXT: if (statQ != ST_BUSY) startNow = 1'b1;
        default: ;
      endcase
      if (startNow) begin
        statD    = ST_BUSY;
        sendingD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ    <= ST_IDLE;
      sendingQ <= 1'b0;
      engStart <= 1'b0;
      engAbort <= 1'b0;
      txIrq    <= 1'b0;
    end else begin
      statQ    <= statD;
      sendingQ <= sendingD;
      engStart <= startNow;
      engAbort <= abortNow;
      txIrq    <= irqNow;
    end
  end

  assign txStatus       = statQ;
  assign strobe.wrOk    = (statQ != ST_BUSY);
  assign strobe.ptrLoad = startNow;
  assign strobe.ptrAdv  = sendingQ && engByteReq && !anyEnd;
endmodule

// File: rtl/cec_txbuf_dp.sv
module cec_txbuf_dp
  import cec_txbuf_pkg::*;
#(
  parameter int MSG_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  txStrobe_t         strobe,
  output logic [DATA_W-1:0] engByte,
  output logic              engLast
);
  localparam int                PTR_W    = $clog2(MSG_BYTES);
  localparam logic [ADDR_W-1:0] LEN_ADDR = ADDR_W'(MSG_BYTES);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(MSG_BYTES + 3);
  localparam logic [DATA_W-1:0] LEN_MAX  = DATA_W'(MSG_BYTES - 1);

  logic [DATA_W-1:0] msgMem [MSG_BYTES];
  logic [PTR_W-1:0]  lenQ, ptrQ;
  logic              clrHoldQ, clrNow, wrAllowed;

  assign clrNow    = clrHoldQ || (regWrEn && regAddr == CLR_ADDR && regWrData[0]);
  assign wrAllowed = regWrEn && strobe.wrOk && !clrNow;

  always_ff @(posedge clk) begin
    if (!rstN) clrHoldQ <= 1'b0;
    else if (regWrEn && regAddr == CLR_ADDR) clrHoldQ <= regWrData[0];
  end

  for (genvar g = 0; g < MSG_BYTES; g++) begin : gByte
    always_ff @(posedge clk) begin
      if (!rstN || clrNow) msgMem[g] <= '0;
      else if (wrAllowed && regAddr == ADDR_W'(g)) msgMem[g] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrNow) lenQ <= '0;
    else if (wrAllowed && regAddr == LEN_ADDR)
      lenQ <= (regWrData > LEN_MAX) ? PTR_W'(MSG_BYTES - 1) : regWrData[PTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.ptrLoad) ptrQ <= '0;
    else if (strobe.ptrAdv && ptrQ != lenQ) ptrQ <= ptrQ + 1'b1;
  end

  assign engByte = msgMem[ptrQ];
  assign engLast = (ptrQ == lenQ);
endmodule

// File: rtl/cec_txbuf_top.sv
module cec_txbuf_top
  import cec_txbuf_pkg::*;
#(
  parameter int MSG_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              engByteReq,
  input  logic              engDone,
  input  logic              engNack,
  input  logic              engArbLost,
  output logic [1:0]        txStatus,
  output logic              txIrq,
  output logic              engStart,
  output logic              engAbort,
  output logic [DATA_W-1:0] engByte,
  output logic              engLast
);
  txStrobe_t strobe;

  cec_txbuf_ctl #(.MSG_BYTES(MSG_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .engByteReq(engByteReq), .engDone(engDone),
    .engNack(engNack), .engArbLost(engArbLost), .strobe(strobe),
    .txStatus(txStatus), .txIrq(txIrq), .engStart(engStart), .engAbort(engAbort)
  );

  cec_txbuf_dp #(.MSG_BYTES(MSG_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .engByte(engByte), .engLast(engLast)
  );
endmodule

// File: rtl/cec_txbuf_chk.sv
module cec_txbuf_chk #(
  parameter int MSG_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              engArbLost,
  input logic [1:0]        txStatus,
  input logic              txIrq,
  input logic              engStart,
  input logic              engAbort
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(MSG_BYTES + 1);

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (txStatus == 2'd1) && ($past(txStatus) != 2'd1));
  assert_abort_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |-> (txStatus == 2'd3) && txIrq);
  assert_done_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txStatus == 2'd2 && $past(txStatus) == 2'd1) |-> txIrq);
  assert_arb_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && txStatus == 2'd1) |-> $past(engArbLost));
  assert_idle_by_nop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txStatus == 2'd0 && $past(txStatus) != 2'd0) |->
      $past(regWrEn && regAddr == CMD_ADDR && regWrData[1:0] == 2'd0));
endmodule

bind cec_txbuf_top cec_txbuf_chk #(.MSG_BYTES(MSG_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .engArbLost(engArbLost), .txStatus(txStatus),
  .txIrq(txIrq), .engStart(engStart), .engAbort(engAbort)
);

// File: tb/cec_txbuf_top_tb.sv
module cec_txbuf_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0;
  logic       engByteReq = 1'b0, engDone = 1'b0, engNack = 1'b0, engArbLost = 1'b0;
  logic [1:0] txStatus;
  logic       txIrq, engStart, engAbort, engLast;
  logic [7:0] engByte;
  int nTests = 0, nFail = 0;

  always #10 clk = ~clk;

  cec_txbuf_top u_dut (.*);

  // vector: [15:12] count-1, [11:4] seed, [1:0] outcome 0 done,1 nack,2 arb
  localparam logic [15:0] VEC [6] = '{
    {4'd0,  8'h40, 4'd0}, {4'd1, 8'h12, 4'd1}, {4'd15, 8'hA0, 4'd0},
    {4'd3,  8'h05, 4'd2}, {4'd7, 8'hF0, 4'd1}, {4'd2,  8'h33, 4'd0}};

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic eng(input logic dn, input logic nk, input logic ar);
    engDone = dn; engNack = nk; engArbLost = ar;
    @(negedge clk);
    engDone = 1'b0; engNack = 1'b0; engArbLost = 1'b0;
  endtask

  task automatic req();
    engByteReq = 1'b1;
    @(negedge clk);
    engByteReq = 1'b0;
  endtask

  task automatic loadFrame(input int len, input logic [7:0] seed);
    for (int i = 0; i <= len; i++) wr(8'(i), 8'(seed + i * 7));
    wr(8'h10, 8'(len));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 status", txStatus, 0);
    check("R1 irq", txIrq, 0);
    check("R1 start", engStart, 0);
    check("R1 byte", engByte, 0);
    check("R1 last", engLast, 1);

    // vector walk: R2 R3 R4 R5 R6 R8 R12
    foreach (VEC[v]) begin
      int len; logic [7:0] seed; int oc;
      len = VEC[v][15:12]; seed = VEC[v][11:4]; oc = VEC[v][1:0];
      loadFrame(len, seed);
      wr(8'h11, 8'd1);
      check("R4 busy after send", txStatus, 1);
      check("R4 start pulse", engStart, 1);
      for (int i = 0; i <= len; i++) begin
        check("R2 byte order", engByte, 8'(seed + i * 7));
        check("R3 last flag", engLast, (i == len));
        req();
      end
      check("R12 index holds at last", engByte, 8'(seed + len * 7));
      eng(oc == 0, oc == 1, oc == 2);
      check("R5 R6 end status", txStatus, (oc == 0) ? 2 : (oc == 1) ? 3 : 1);
      check("R5 irq pulse", txIrq, 1);
      @(negedge clk);
      check("R5 irq single", txIrq, 0);
      wr(8'h11, 8'd0);
      check("R8 nop to idle", txStatus, 0);
    end

    // R3 clamp
    loadFrame(15, 8'h01);
    wr(8'h10, 8'd40);
    wr(8'h11, 8'd1);
    check("R3 clamp not last at 0", engLast, 0);
    for (int i = 0; i < 15; i++) req();
    check("R3 clamp last at 15", engLast, 1);
    check("R3 clamp byte 15", engByte, 8'(1 + 15 * 7));
    eng(1'b1, 1'b0, 1'b0);
    wr(8'h11, 8'd0);

    // R11 writes ignored while busy
    loadFrame(2, 8'h20);
    wr(8'h11, 8'd1);
    wr(8'h00, 8'hEE);
    wr(8'h10, 8'd0);
    check("R11 byte kept", engByte, 8'h20);
    check("R11 length kept", engLast, 0);
    // R8 nop while sending ignored
    wr(8'h11, 8'd0);
    check("R8 nop while sending", txStatus, 1);
    eng(1'b1, 1'b0, 1'b0);
    check("R5 done", txStatus, 2);
    // R4 send ignored when not idle
    wr(8'h11, 8'd1);
    check("R4 send ignored status", txStatus, 2);
    check("R4 send ignored start", engStart, 0);
    // R9 send-next from done
    wr(8'h11, 8'd3);
    check("R9 busy", txStatus, 1);
    check("R9 start", engStart, 1);
    check("R9 index reset", engByte, 8'h20);
    // R7 abort while busy
    wr(8'h11, 8'd2);
    check("R7 abort status", txStatus, 3);
    check("R7 abort pulse", engAbort, 1);
    check("R7 abort irq", txIrq, 1);
    @(negedge clk);
    check("R7 abort single", engAbort, 0);
    wr(8'h11, 8'd0);
    wr(8'h11, 8'd2);
    check("R7 abort idle status", txStatus, 0);
    check("R7 abort idle pulse", engAbort, 0);
    check("R7 abort idle irq", txIrq, 0);

    // R5 nack wins over done; completions ignored while idle
    wr(8'h11, 8'd1);
    eng(1'b1, 1'b1, 1'b0);
    check("R5 nack priority", txStatus, 3);
    wr(8'h11, 8'd0);
    eng(1'b1, 1'b0, 1'b0);
    check("R5 idle ignore status", txStatus, 0);
    check("R5 idle ignore irq", txIrq, 0);

    // R6 arb lost then R8 nop
    wr(8'h11, 8'd1);
    eng(1'b0, 1'b0, 1'b1);
    check("R6 arb busy", txStatus, 1);
    check("R6 arb irq", txIrq, 1);
    wr(8'h00, 8'h99);
    wr(8'h11, 8'd0);
    check("R8 nop after arb", txStatus, 0);

    // R10 clear
    loadFrame(2, 8'h50);
    wr(8'h13, 8'd1);
    wr(8'h00, 8'h77);
    wr(8'h13, 8'd0);
    wr(8'h11, 8'd1);
    check("R10 byte cleared", engByte, 0);
    check("R10 length cleared", engLast, 1);
    eng(1'b1, 1'b0, 1'b0);
    wr(8'h11, 8'd0);
    wr(8'h00, 8'h77);
    wr(8'h11, 8'd1);
    check("R10 write after release", engByte, 8'h77);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule